// File: doc/BRIEF.md
# Tightly coupled memory region decoder

This block holds the placement of two local memory windows, one serving instruction fetches and one serving data accesses. For every physical address presented on its lookup input it reports, in the same cycle, whether that address lands in the instruction window, the data window, or in neither. Each window is placed by a write on one configuration port. The write carries a window select, a base address and a power-of-two size code.

The block checks every configuration write before storing it. A base that is not a multiple of the window size, or a size code outside the supported set, is rejected and reported as an alignment error. A well-formed window that would share any byte with the other enabled window is rejected and reported as an overlap error. A rejected write leaves the addressed window disabled. Both error flags are sticky until reset. A disabled window never reports a hit, so the two hit flags can never both be high.

Top module: `tcm_region_decoder`

## Requirements
- R1: After a synchronous active-high reset, both windows are disabled, `ihit_o` and `dhit_o` are low for every address, and `err_align_o` and `err_overlap_o` are low.
- R2: Size code 0 disables a window. A code c from 1 to 9 gives a window of 2^(11+c) bytes, which spans 4 KB to 1 MB. An enabled window hits exactly when base <= addr < base + size.
- R3: `cfg_sel` = 0 addresses the instruction window and `cfg_sel` = 1 addresses the data window. A write takes effect from the clock edge that samples it. A lookup made in the same cycle as the write uses the old placement.
- R4: A write with a code from 1 to 9 whose base is not a multiple of the window size sets `err_align_o` after the edge and leaves that window disabled.
- R5: A write with a code from 10 to 15 sets `err_align_o` after the edge and leaves that window disabled.
- R6: A well-formed write whose window shares a byte with the other enabled window sets `err_overlap_o` after the edge and leaves the written window disabled. The other window is unchanged. Windows that only touch at an edge are legal.
- R7: A write with code 0 is always legal. It disables the window and raises no error.
- R8: Both error flags stay high until reset. A later legal write does not clear them, but it restores its window.
- R9: `ihit_o` and `dhit_o` are never high together.
- R10: Each hit flag depends only on its own window. Addresses outside both windows give no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Window select: 0 instruction, 1 data |
| cfg_base | input | ADDR_W | Window base address |
| cfg_size | input | CODE_W | Size code: 0 off, c gives 2^(11+c) bytes |
| addr_i | input | ADDR_W | Physical lookup address |
| ihit_o | output | 1 | Address is in the instruction window |
| dhit_o | output | 1 | Address is in the data window |
| err_align_o | output | 1 | Sticky: misaligned base or bad size code seen |
| err_overlap_o | output | 1 | Sticky: overlapping placement seen |

## Verification
A configuration write and an address lookup can fall in the same cycle. The bench provokes this by writing a window while the lookup address already points inside the new window. The hit must stay low in that cycle and rise only in the next one. A second collision occurs when a window is rewritten onto a spot overlapping the other window while the lookup watches the other window. That window must keep hitting while the written window drops out and the overlap flag rises.

// File: rtl/tcm_dec_pkg.sv
package tcm_dec_pkg;
  // window select encoding on the configuration port
  typedef enum logic {
    WIN_INSTR = 1'b0,
    WIN_DATA  = 1'b1
  } win_sel_e;

  localparam int unsigned DEF_ADDR_W    = 32;
  localparam int unsigned DEF_CODE_W    = 4;
  localparam int unsigned DEF_MIN_SHIFT = 12;  // code 1 -> 2^12 bytes
  localparam int unsigned DEF_MAX_CODE  = 9;   // code 9 -> 2^20 bytes
endpackage

// File: rtl/tcm_region_slot.sv
module tcm_region_slot #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned MIN_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_base,
  input  logic [CODE_W-1:0] ld_code,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] base_q,
  output logic [CODE_W-1:0] code_q,
  output logic [ADDR_W-1:0] mask_q,
  output logic              hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      code_q <= '0;
    end else if (load) begin
      base_q <= ld_base;
      code_q <= ld_code;
    end
  end

  // upper-bit mask of the stored window; all ones while disabled
  always_comb begin
    if (code_q == '0) mask_q = '1;
    else mask_q = {ADDR_W{1'b1}} << (MIN_SHIFT - 1 + int'(code_q));
  end

  assign hit = (code_q != '0) && (((addr ^ base_q) & mask_q) == '0);
endmodule

// File: rtl/tcm_cfg_check.sv
module tcm_cfg_check #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned MIN_SHIFT = 12,
  parameter int unsigned MAX_CODE  = 9
) (
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [ADDR_W-1:0] oth_base,
  input  logic [CODE_W-1:0] oth_code,
  input  logic [ADDR_W-1:0] oth_mask,
  output logic              size_bad,
  output logic              align_bad,
  output logic              overlap_bad,
  output logic [CODE_W-1:0] store_code
);
  logic [ADDR_W-1:0] wr_mask;
  logic              wr_on;

  assign wr_on = (wr_code != '0);

  always_comb begin
    if (!wr_on || size_bad) wr_mask = '1;
    else wr_mask = {ADDR_W{1'b1}} << (MIN_SHIFT - 1 + int'(wr_code));
  end

  assign size_bad  = wr_on && (int'(wr_code) > int'(MAX_CODE));
  assign align_bad = wr_on && !size_bad && ((wr_base & ~wr_mask) != '0);
  // aligned power-of-two windows collide when they agree above the larger size
  assign overlap_bad = wr_on && !size_bad && !align_bad && (oth_code != '0) &&
                       (((wr_base ^ oth_base) & wr_mask & oth_mask) == '0);
  assign store_code = (size_bad || align_bad || overlap_bad) ? '0 : wr_code;
endmodule

// File: rtl/tcm_region_decoder.sv
module tcm_region_decoder
  import tcm_dec_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned CODE_W    = DEF_CODE_W,
  parameter int unsigned MIN_SHIFT = DEF_MIN_SHIFT,
  parameter int unsigned MAX_CODE  = DEF_MAX_CODE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [CODE_W-1:0] cfg_size,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ihit_o,
  output logic              dhit_o,
  output logic              err_align_o,
  output logic              err_overlap_o
);
  localparam int unsigned NWIN = 2;

  logic [ADDR_W-1:0] base_q  [NWIN];
  logic [CODE_W-1:0] code_q  [NWIN];
  logic [ADDR_W-1:0] mask_q  [NWIN];
  logic [CODE_W-1:0] st_code [NWIN];
  logic [NWIN-1:0]   hit, sz_bad, al_bad, ov_bad;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam int unsigned OTH = NWIN - 1 - g;

    tcm_cfg_check #(
      .ADDR_W(ADDR_W), .CODE_W(CODE_W), .MIN_SHIFT(MIN_SHIFT), .MAX_CODE(MAX_CODE)
    ) u_check (
      .wr_base    (cfg_base),
      .wr_code    (cfg_size),
      .oth_base   (base_q[OTH]),
      .oth_code   (code_q[OTH]),
      .oth_mask   (mask_q[OTH]),
      .size_bad   (sz_bad[g]),
      .align_bad  (al_bad[g]),
      .overlap_bad(ov_bad[g]),
      .store_code (st_code[g])
    );

    tcm_region_slot #(
      .ADDR_W(ADDR_W), .CODE_W(CODE_W), .MIN_SHIFT(MIN_SHIFT)
    ) u_slot (
      .clk    (clk),
      .rst    (rst),
      .load   (cfg_we && (cfg_sel == 1'(g))),
      .ld_base(cfg_base),
      .ld_code(st_code[g]),
      .addr   (addr_i),
      .base_q (base_q[g]),
      .code_q (code_q[g]),
      .mask_q (mask_q[g]),
      .hit    (hit[g])
    );
  end

  assign ihit_o = hit[WIN_INSTR];
  assign dhit_o = hit[WIN_DATA];

  always_ff @(posedge clk) begin
    if (rst) begin
      err_align_o   <= 1'b0;
      err_overlap_o <= 1'b0;
    end else if (cfg_we) begin
      err_align_o   <= err_align_o   | sz_bad[cfg_sel] | al_bad[cfg_sel];
      err_overlap_o <= err_overlap_o | ov_bad[cfg_sel];
    end
  end
endmodule

// File: rtl/tcm_region_decoder_chk.sv
module tcm_region_decoder_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned MIN_SHIFT = 12,
  parameter int unsigned MAX_CODE  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic              cfg_sel,
  input logic [ADDR_W-1:0] cfg_base,
  input logic [CODE_W-1:0] cfg_size,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ihit_o,
  input logic              dhit_o,
  input logic              err_align_o,
  input logic              err_overlap_o
);
  logic [ADDR_W-1:0] low_bits;
  always_comb begin
    if (cfg_size == '0 || int'(cfg_size) > int'(MAX_CODE)) low_bits = '0;
    else low_bits = ~({ADDR_W{1'b1}} << (MIN_SHIFT - 1 + int'(cfg_size)));
  end

  // R9
  no_dual_hit_chk: assert property (@(posedge clk) disable iff (rst)
    !(ihit_o && dhit_o));
  // R8
  align_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_align_o |=> err_align_o);
  // R8
  overlap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_overlap_o |=> err_overlap_o);
  // R4
  misalign_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && ((cfg_base & low_bits) != '0)) |=> err_align_o);
  // R5
  bad_code_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && int'(cfg_size) > int'(MAX_CODE)) |=> err_align_o);
  // R7
  off_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_size == '0 && !cfg_sel) |=> !ihit_o);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we ##1 $stable(addr_i)) |-> ($stable(ihit_o) && $stable(dhit_o)));
endmodule

bind tcm_region_decoder tcm_region_decoder_chk #(
  .ADDR_W(ADDR_W), .CODE_W(CODE_W), .MIN_SHIFT(MIN_SHIFT), .MAX_CODE(MAX_CODE)
) u_chk (.*);

// File: tb/tcm_region_decoder_bench.sv
module tcm_region_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [3:0]  cfg_size = '0;
  logic [31:0] addr_i = '0;
  logic        ihit_o, dhit_o, err_align_o, err_overlap_o;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  longint unsigned m_base [2];
  int              m_code [2];
  bit              m_ea, m_eo;

  always #2 clk = ~clk;  // 250 MHz

  tcm_region_decoder u_tcm_region_decoder (.*);

  function automatic longint unsigned wsize(int c);
    return 64'd1 << (11 + c);
  endfunction

  function automatic bit m_hit(int r, longint unsigned a);
    if (m_code[r] == 0) return 1'b0;
    return (a >= m_base[r]) && (a < m_base[r] + wsize(m_code[r]));
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < 2; r++) begin
      m_base[r] = 0;
      m_code[r] = 0;
    end
    m_ea = 0;
    m_eo = 0;
  endtask

  task automatic model_write(bit sel, longint unsigned b, int c);
    int o;
    o = sel ? 0 : 1;
    if (c == 0) begin
      m_base[sel] = b; m_code[sel] = 0;
    end else if (c > 9 || (b % wsize(c)) != 0) begin
      m_ea = 1; m_base[sel] = b; m_code[sel] = 0;
    end else if (m_code[o] != 0 && b < m_base[o] + wsize(m_code[o]) &&
                 m_base[o] < b + wsize(c)) begin
      m_eo = 1; m_base[sel] = b; m_code[sel] = 0;
    end else begin
      m_base[sel] = b; m_code[sel] = c;
    end
  endtask

  // one clock: drive, compare against the model, then advance the model
  task automatic step(bit we, bit sel, longint unsigned b, int c,
                      longint unsigned a, string tag);
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_base = b[31:0]; cfg_size = c[3:0];
    addr_i = a[31:0];
    #1;
    chk(tag, "ihit", ihit_o, m_hit(0, a));
    chk(tag, "dhit", dhit_o, m_hit(1, a));
    chk(tag, "err_align", err_align_o, m_ea);
    chk(tag, "err_overlap", err_overlap_o, m_eo);
    if (we) model_write(sel, b, c);
  endtask

  task automatic look(longint unsigned a, string tag);
    step(1'b0, 1'b0, 0, 0, a, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R1 reset state
    look(32'h0000_0000, "R1");
    look(32'hFFFF_F000, "R1");

    // R2 64 KB instruction window and its edges
    step(1, 0, 32'h0001_0000, 5, 32'h0001_0000, "R3");
    look(32'h0001_0000, "R2");
    look(32'h0001_FFFF, "R2");
    look(32'h0002_0000, "R2");
    look(32'h0000_FFFF, "R10");

    // R3 write and lookup in the same cycle: old placement used
    step(1, 1, 32'h0010_0000, 9, 32'h0010_0004, "R3");
    look(32'h0010_0004, "R3");
    look(32'h001F_FFFF, "R2");
    look(32'h0020_0000, "R10");

    // R6 instruction window moved onto the data window
    step(1, 0, 32'h0018_0000, 1, 32'h0018_0000, "R6");
    look(32'h0018_0000, "R6");
    look(32'h0001_0000, "R6");

    // R4 misaligned base
    step(1, 0, 32'h0000_1800, 1, 32'h0000_1800, "R4");
    look(32'h0000_1800, "R4");
    // R5 code above the supported range
    step(1, 0, 32'h0000_0000, 12, 32'h0000_0000, "R5");
    look(32'h0000_0000, "R5");

    // R8 a legal write restores the window, flags stay
    step(1, 0, 32'h0000_2000, 1, 32'h0000_2FFF, "R8");
    look(32'h0000_2FFF, "R8");
    look(32'h0000_3000, "R8");

    // R7 code 0 disables the data window
    step(1, 1, 32'h0000_0000, 0, 32'h0010_0000, "R7");
    look(32'h0010_0000, "R7");

    // R6 touching windows are legal
    step(1, 1, 32'h0000_3000, 1, 32'h0000_3000, "R6");
    look(32'h0000_2FFF, "R6");
    look(32'h0000_3000, "R6");
    look(32'h0000_4000, "R10");

    // R7 and R1: new reset, then code 0 raises nothing
    do_reset();
    look(32'h0000_2000, "R1");
    step(1, 1, 32'h0000_0000, 0, 32'h0, "R7");
    look(32'h0, "R7");

    // R6 instruction window placed inside a larger data window
    step(1, 1, 32'h0000_4000, 2, 32'h0000_4000, "R6");
    step(1, 0, 32'h0000_2000, 1, 32'h0000_5000, "R6");
    step(1, 0, 32'h0000_5000, 1, 32'h0000_5000, "R6");
    look(32'h0000_5000, "R6");
    look(32'h0000_2000, "R9");

    // R9 R10 sweep across both windows
    for (int k = 0; k < 24; k++) look(longint'(k) * 32'h0000_0400, "R9");

    // R4 misaligned large window after reset
    do_reset();
    step(1, 1, 32'h0008_0000, 9, 32'h0008_0000, "R4");
    look(32'h0008_0000, "R4");

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule